// File: doc/BRIEF.md
# Multi-Sector Erase Scheduler with Status Flags

This block sits behind a flash command decoder and owns the sector erase operation. The first sector erase command opens a collection window and marks its sector in a bitmap. Each further sector erase command marks one more sector and starts the window again. When the window runs out with no new request, a modelled erase runs across every marked sector. Its length is a fixed number of clock cycles per sector. The erase can be paused with a suspend pulse and continued with a resume pulse. Any other command written while the window is open abandons the whole queue.

While the block is busy it produces the flag bits that a host reads instead of array data. The polling bit reads low until the erase is done. The toggle bit flips on every status read. The time-limit bit rises if the erase runs longer than a set number of cycles. The sector-toggle bit flips only when a status read addresses a sector that is in the queue. Once the limit is exceeded the block stays in that state until the decoder reports a command, for example the reset command. No data streams through the block, so it has no valid/ready interface: every input is a single-cycle pulse or a level, and every output is a plain level.

Top module: `erase_sched`

## Requirements
- R1: After reset, `ready`=1, `dq7`=1, `dq5`=0 and `erase_map`=0.
- R2: A `se_pulse` while idle sets bit `se_sector` of `erase_map` (bit i is sector i) and drives `ready` and `dq7` low from the next cycle.
- R3: A `se_pulse` while the window is open adds its sector and restarts the window. This includes a pulse in the window's final cycle, which keeps the erase from starting.
- R4: The erase starts WINDOW_CYC cycles after the last accepted `se_pulse` and lasts ERASE_CYC cycles per marked sector. After that `ready` returns to 1 and `erase_map` to 0, so with no suspend `ready` rises WINDOW_CYC + ERASE_CYC×count cycles after the last request.
- R5: An `other_cmd` pulse while the window is open clears `erase_map` and returns the block to idle (`ready`=1). A `susp_pulse` in the window is ignored.
- R6: A `susp_pulse` during the erase pauses it. While paused, `ready`=1, `dq7`=1, `erase_map` is held and the erase count is frozen. A `resume_pulse` continues the erase from where it stopped.
- R7: `dq6` inverts on each `stat_rd` while the block is busy (`ready`=0, including the failed state) and holds its value otherwise.
- R8: If the erase reaches LIMIT_CYC cycles before it is done, `dq5` becomes 1 and `ready` stays 0 until an `other_cmd` pulse, which returns the block to idle. If completion falls in the same cycle as the limit, completion wins and `dq5` stays 0.
- R9: `dq2` inverts on a `stat_rd` whose `rd_sector` is marked in `erase_map` while an erase is pending (window, erase, suspend or failed). A read of an unmarked sector leaves it unchanged.
- R10: `se_pulse` and `other_cmd` during the running erase are ignored: the map and the duration do not change.
- R11: `dq7` reads 0 while busy and 1 when idle or suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| se_pulse | input | 1 | Sector erase command decoded |
| se_sector | input | SW | Sector addressed by the erase command |
| susp_pulse | input | 1 | Erase suspend command decoded |
| resume_pulse | input | 1 | Erase resume command decoded |
| other_cmd | input | 1 | Any other command decoded (includes the reset command) |
| stat_rd | input | 1 | A status read is taking place |
| rd_sector | input | SW | Sector addressed by the status read |
| ready | output | 1 | 1 = idle or suspended, 0 = busy |
| dq7 | output | 1 | Polling bit |
| dq6 | output | 1 | Toggle bit |
| dq5 | output | 1 | Time limit exceeded |
| dq2 | output | 1 | Sector toggle bit for queued sectors |
| erase_map | output | NUM_SECT | Sectors queued or being erased |

## Verification
Two pairs of events can land in the same cycle. In the first, a new sector erase request arrives in the very cycle the window would expire. The bench sends it exactly WINDOW_CYC-1 cycles after the previous request and passes only if both sectors are in the map and `ready` rises a full window plus two erase periods later. In the second, the erase finishes in the cycle that also reaches the time limit. The bench queues exactly as many sectors as fill the limit, and passes only if `dq5` never rises and `ready` returns on time.

// File: rtl/es_pkg.sv
package es_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_ERASE,
    ST_SUSP,
    ST_FAIL
  } es_state_t;
endpackage

// File: rtl/es_queue.sv
module es_queue #(
  parameter int NUM_SECT = 8,
  parameter int SW = 3,
  localparam int NW = $clog2(NUM_SECT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                add,
  input  logic                clr,
  input  logic [SW-1:0]       sector,
  output logic [NUM_SECT-1:0] map,
  output logic [NW-1:0]       count
);
  for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        map[i] <= 1'b0;
      else if (add && (sector == SW'(i)))
        map[i] <= 1'b1;
    end
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NUM_SECT; i++)
      count = count + NW'(map[i]);
  end
endmodule

// File: rtl/es_timer.sv
module es_timer #(
  parameter int NUM_SECT   = 8,
  parameter int WINDOW_CYC = 12,
  parameter int ERASE_CYC  = 20,
  parameter int LIMIT_CYC  = 60,
  localparam int NW   = $clog2(NUM_SECT + 1),
  localparam int WW   = $clog2(WINDOW_CYC + 1),
  localparam int TMAX = ERASE_CYC * NUM_SECT,
  localparam int CMAX = (TMAX > LIMIT_CYC) ? TMAX : LIMIT_CYC,
  localparam int CW   = $clog2(CMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_restart,
  input  logic          win_run,
  input  logic          er_start,
  input  logic          er_run,
  input  logic [NW-1:0] nsect,
  output logic          win_done,
  output logic          er_done,
  output logic          er_limit
);
  logic [WW-1:0] win_cnt;
  logic [CW-1:0] er_cnt;
  logic [CW-1:0] target;

  always_ff @(posedge clk) begin
    if (!rst_n || win_restart)
      win_cnt <= '0;
    else if (win_run)
      win_cnt <= win_cnt + WW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || er_start)
      er_cnt <= '0;
    else if (er_run)
      er_cnt <= er_cnt + CW'(1);
  end

  assign target   = CW'(ERASE_CYC) * CW'(nsect);
  assign win_done = win_run && (win_cnt == WW'(WINDOW_CYC - 1));
  assign er_done  = er_run && (er_cnt == target - CW'(1));
  assign er_limit = er_run && (er_cnt == CW'(LIMIT_CYC - 1));
endmodule

// File: rtl/es_status.sv
module es_status (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic pending,
  input  logic stat_rd,
  input  logic hit,
  output logic dq6,
  output logic dq2
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq6 <= 1'b0;
      dq2 <= 1'b0;
    end else begin
      if (stat_rd && busy)
        dq6 <= ~dq6;
      if (stat_rd && pending && hit)
        dq2 <= ~dq2;
    end
  end
endmodule

// File: rtl/erase_sched.sv
module erase_sched #(
  parameter int NUM_SECT   = 8,
  parameter int WINDOW_CYC = 12,
  parameter int ERASE_CYC  = 20,
  parameter int LIMIT_CYC  = 60,
  localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int NW = $clog2(NUM_SECT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                se_pulse,
  input  logic [SW-1:0]       se_sector,
  input  logic                susp_pulse,
  input  logic                resume_pulse,
  input  logic                other_cmd,
  input  logic                stat_rd,
  input  logic [SW-1:0]       rd_sector,
  output logic                ready,
  output logic                dq7,
  output logic                dq6,
  output logic                dq5,
  output logic                dq2,
  output logic [NUM_SECT-1:0] erase_map
);
  import es_pkg::*;

  es_state_t     state, state_n;
  logic          win_done, er_done, er_limit;
  logic          busy, pending, hit, add, clr;
  logic [NW-1:0] nsect;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:  if (se_pulse) state_n = ST_WIN;
      ST_WIN: begin
        if (other_cmd)     state_n = ST_IDLE;
        else if (se_pulse) state_n = ST_WIN;
        else if (win_done) state_n = ST_ERASE;
      end
      ST_ERASE: begin
        if (er_done)         state_n = ST_IDLE;
        else if (er_limit)   state_n = ST_FAIL;
        else if (susp_pulse) state_n = ST_SUSP;
      end
      ST_SUSP:  if (resume_pulse) state_n = ST_ERASE;
      ST_FAIL:  if (other_cmd) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

  assign add = se_pulse && (state_n == ST_WIN)
               && ((state == ST_IDLE) || (state == ST_WIN));
  assign clr = (state != ST_IDLE) && (state_n == ST_IDLE);

  es_queue #(.NUM_SECT(NUM_SECT), .SW(SW)) u_queue (
    .clk(clk), .rst_n(rst_n), .add(add), .clr(clr),
    .sector(se_sector), .map(erase_map), .count(nsect)
  );

  es_timer #(
    .NUM_SECT(NUM_SECT), .WINDOW_CYC(WINDOW_CYC),
    .ERASE_CYC(ERASE_CYC), .LIMIT_CYC(LIMIT_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .win_restart(add), .win_run(state == ST_WIN),
    .er_start((state == ST_WIN) && (state_n == ST_ERASE)),
    .er_run(state == ST_ERASE), .nsect(nsect),
    .win_done(win_done), .er_done(er_done), .er_limit(er_limit)
  );

  assign busy    = (state == ST_WIN) || (state == ST_ERASE) || (state == ST_FAIL);
  assign pending = (state != ST_IDLE);
  assign hit     = (32'(rd_sector) < NUM_SECT) && erase_map[rd_sector];

  es_status u_status (
    .clk(clk), .rst_n(rst_n), .busy(busy), .pending(pending),
    .stat_rd(stat_rd), .hit(hit), .dq6(dq6), .dq2(dq2)
  );

  assign ready = !busy;
  assign dq7   = !busy;
  assign dq5   = (state == ST_FAIL);
endmodule

// File: rtl/es_checker.sv
module es_checker #(
  parameter int NUM_SECT = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                other_cmd,
  input logic                stat_rd,
  input logic                ready,
  input logic                dq6,
  input logic                dq5,
  input logic [NUM_SECT-1:0] erase_map,
  input es_pkg::es_state_t   state
);
  import es_pkg::*;

  AST_BUSY_HAS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (erase_map != '0)); // R2

  AST_ABORT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WIN) && other_cmd) |=> (ready && (erase_map == '0))); // R5

  AST_SUSP_HOLDS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP) |=> $stable(erase_map)); // R6

  AST_DQ6_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && stat_rd) |=> (dq6 != $past(dq6))); // R7

  AST_DQ6_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> $stable(dq6)); // R7

  AST_DQ5_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (dq5 && !other_cmd) |=> dq5); // R8

  AST_DQ5_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    dq5 |-> !ready); // R8
endmodule

bind erase_sched es_checker #(.NUM_SECT(NUM_SECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .other_cmd(other_cmd), .stat_rd(stat_rd),
  .ready(ready), .dq6(dq6), .dq5(dq5), .erase_map(erase_map), .state(state)
);

// File: tb/erase_sched_tb.sv
`timescale 1ns/1ps
module erase_sched_tb;
  localparam int W = 12, E = 20, L = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic se_pulse = 0, susp_pulse = 0, resume_pulse = 0, other_cmd = 0, stat_rd = 0;
  logic [2:0] se_sector = '0, rd_sector = '0;
  logic ready, dq7, dq6, dq5, dq2;
  logic [7:0] erase_map;
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  erase_sched #(.NUM_SECT(8), .WINDOW_CYC(W), .ERASE_CYC(E), .LIMIT_CYC(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .se_pulse(se_pulse), .se_sector(se_sector),
    .susp_pulse(susp_pulse), .resume_pulse(resume_pulse), .other_cmd(other_cmd),
    .stat_rd(stat_rd), .rd_sector(rd_sector), .ready(ready), .dq7(dq7),
    .dq6(dq6), .dq5(dq5), .dq2(dq2), .erase_map(erase_map)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic se(input int s);
    se_pulse = 1; se_sector = 3'(s); @(negedge clk); se_pulse = 0;
  endtask
  task automatic susp();   susp_pulse = 1;   @(negedge clk); susp_pulse = 0;   endtask
  task automatic resume(); resume_pulse = 1; @(negedge clk); resume_pulse = 0; endtask
  task automatic other();  other_cmd = 1;    @(negedge clk); other_cmd = 0;    endtask
  task automatic rd(input int s);
    stat_rd = 1; rd_sector = 3'(s); @(negedge clk); stat_rd = 0;
  endtask

  task automatic wait_ready(input int st, output int d, output bit saw5);
    saw5 = 0;
    for (int k = 0; k < 5000 && !ready; k++) begin
      @(negedge clk);
      if (dq5) saw5 = 1;
    end
    d = cyc - st;
  endtask

  task automatic t_reset();
    check(ready == 1, "R1 ready", int'(ready), 1);
    check(dq7 == 1, "R1 dq7", int'(dq7), 1);
    check(dq5 == 0, "R1 dq5", int'(dq5), 0);
    check(erase_map == 0, "R1 map", int'(erase_map), 0);
  endtask

  task automatic t_single();
    int st, d; bit s5;
    se(2); st = cyc;
    check(ready == 0, "R2 ready", int'(ready), 0);
    check(erase_map == 8'h04, "R2 map", int'(erase_map), 4);
    check(dq7 == 0, "R11 dq7 busy", int'(dq7), 0);
    wait_ready(st, d, s5);
    check(d == W + E, "R4 duration", d, W + E);
    check(erase_map == 0, "R4 map cleared", int'(erase_map), 0);
    check(dq7 == 1, "R11 dq7 done", int'(dq7), 1);
  endtask

  task automatic t_multi();
    int st, d; bit s5;
    se(1); repeat (5) @(negedge clk); se(5); st = cyc;
    check(erase_map == 8'h22, "R3 map", int'(erase_map), 'h22);
    wait_ready(st, d, s5);
    check(d == W + 2 * E, "R3 restart", d, W + 2 * E);
  endtask

  task automatic t_edge();
    int st, d; bit s5;
    se(0); repeat (W - 1) @(negedge clk); se(6); st = cyc;
    check(erase_map == 8'h41, "R3 last-cycle add", int'(erase_map), 'h41);
    wait_ready(st, d, s5);
    check(d == W + 2 * E, "R3 last-cycle timing", d, W + 2 * E);
  endtask

  task automatic t_abort();
    se(3); se(4); susp();
    check(ready == 0 && erase_map == 8'h18, "R5 susp ignored", int'(erase_map), 'h18);
    other();
    check(ready == 1, "R5 abort ready", int'(ready), 1);
    check(erase_map == 0, "R5 abort map", int'(erase_map), 0);
  endtask

  task automatic t_toggle();
    int st, d; bit s5; logic p6, p2;
    se(0); st = cyc;
    for (int k = 0; k < 3; k++) begin
      p6 = dq6; p2 = dq2; rd(0);
      check(dq6 == !p6, "R7 toggle busy", int'(dq6), int'(!p6));
      check(dq2 == !p2, "R9 dq2 queued", int'(dq2), int'(!p2));
    end
    p2 = dq2; rd(4);
    check(dq2 == p2, "R9 dq2 other sector", int'(dq2), int'(p2));
    wait_ready(st, d, s5);
    p6 = dq6; rd(0);
    check(dq6 == p6, "R7 no toggle idle", int'(dq6), int'(p6));
  endtask

  task automatic t_susp();
    int st, d; bit s5; logic p6, p2;
    se(7); st = cyc;
    repeat (W + 5) @(negedge clk);
    susp();
    check(ready == 1, "R6 ready in suspend", int'(ready), 1);
    check(dq7 == 1, "R11 dq7 suspend", int'(dq7), 1);
    p6 = dq6; p2 = dq2; rd(7);
    check(dq2 == !p2, "R9 dq2 in suspend", int'(dq2), int'(!p2));
    check(dq6 == p6, "R7 dq6 held in suspend", int'(dq6), int'(p6));
    rd(1);
    check(dq2 == !p2, "R9 dq2 unqueued", int'(dq2), int'(!p2));
    repeat (8) @(negedge clk);
    check(erase_map == 8'h80, "R6 map held", int'(erase_map), 'h80);
    resume();
    check(ready == 0, "R6 resumed busy", int'(ready), 0);
    wait_ready(st, d, s5);
    check(d == W + E + 11, "R6 frozen count", d, W + E + 11);
  endtask

  task automatic t_ignore();
    int st, d; bit s5;
    se(1); st = cyc;
    repeat (W + 2) @(negedge clk);
    se(4); other();
    check(erase_map == 8'h02 && ready == 0, "R10 map", int'(erase_map), 2);
    wait_ready(st, d, s5);
    check(d == W + E, "R10 duration", d, W + E);
  endtask

  task automatic t_fail();
    int st; logic p6;
    se(0); se(1); se(2); se(3); st = cyc;
    repeat (W + L - 1) @(negedge clk);
    check(dq5 == 0, "R8 before limit", int'(dq5), 0);
    @(negedge clk);
    check(dq5 == 1, "R8 limit dq5", int'(dq5), 1);
    check(ready == 0, "R8 limit busy", int'(ready), 0);
    p6 = dq6; rd(0);
    check(dq6 == !p6, "R7 toggle in fail", int'(dq6), int'(!p6));
    repeat (30) @(negedge clk);
    check(dq5 == 1, "R8 sticky", int'(dq5), 1);
    other();
    check(dq5 == 0 && ready == 1, "R8 cleared", int'(ready), 1);
    check(erase_map == 0, "R8 map", int'(erase_map), 0);
  endtask

  task automatic t_collide();
    int st, d; bit s5;
    se(4); se(5); se(6); st = cyc;
    wait_ready(st, d, s5);
    check(!s5, "R8 completion beats limit", int'(s5), 0);
    check(d == W + L, "R8 collide duration", d, W + L);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_single(); t_multi(); t_edge(); t_abort();
    t_toggle(); t_susp(); t_ignore(); t_fail(); t_collide();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule